// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address by adding it to one of four 16-bit segment bases, each shifted left by four bits. The sum wraps inside a 1 MB address space. The block holds the four segment bases (extra, code, stack, data) and the instruction pointer. For each access it picks a segment from the kind of base that formed the offset:

- Instruction fetch uses the code segment.
- Stack-pointer or frame-pointer relative accesses use the stack segment.
- Every other data access uses the data segment.

A valid override select replaces the default segment for data accesses. It does not replace it for instruction fetch.

Ordinary writes may load the extra, stack and data bases. The code base is loaded only through a far-transfer port, which writes the code base and the instruction pointer in the same cycle. A separate combinational helper computes the next string index from the direction flag and the element size. Address generation and the string step are combinational. Base and pointer updates take effect at the next clock edge.

Top module: `seg_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, the code base is 0xFFFF, the instruction pointer is 0, and the extra, stack and data bases are 0.
- R2: `phys_addr` equals (selected base × 16 + offset) modulo 2^20, so an address above 0xFFFFF wraps to the bottom of memory.
- R3: With `acc_base` = 0 (instruction fetch), the address uses the code base and the instruction pointer. The `offset` input and any override are ignored.
- R4: With `acc_base` = 1 (stack pointer) or 2 (frame pointer) and no valid override, the stack base is used.
- R5: With `acc_base` = 3, 4, 5, 6 or 7 (base index, source index, destination index, direct or general register) and no valid override, the data base is used.
- R6: For a non-fetch access with `ovr_valid` high, the segment named by `ovr_seg` is used. The select code is 0 for extra, 1 for code, 2 for stack and 3 for data.
- R7: `seg_we` loads `seg_wdata` into the segment named by `seg_wsel` (same code as R6) at the next edge. A write that names the code segment (code 1) leaves the code base unchanged.
- R8: `far_ld` loads `far_cs` into the code base and `far_ip` into the instruction pointer at the same edge. `far_ld` takes priority over `ip_we`. `ip_we` alone loads `ip_wdata`.
- R9: `str_next` is `str_idx` plus the step when `dir_flag` is 0 and minus the step when it is 1. The step is 2 when `str_word` is 1 and 1 otherwise. The result wraps in 16 bits.
- R10: `seg_used` reports the code of the segment that formed `phys_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_we | input | 1 | Direct segment write strobe |
| seg_wsel | input | 2 | Segment code for the direct write |
| seg_wdata | input | 16 | Value for the direct write |
| far_ld | input | 1 | Far-transfer load strobe |
| far_cs | input | 16 | New code base on far transfer |
| far_ip | input | 16 | New instruction pointer on far transfer |
| ip_we | input | 1 | Near instruction-pointer load strobe |
| ip_wdata | input | 16 | Near instruction-pointer value |
| acc_base | input | 3 | Kind of base that formed the offset (0 = fetch) |
| offset | input | 16 | Offset for data accesses |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| str_idx | input | 16 | Current string index |
| str_word | input | 1 | 1 = word element, 0 = byte element |
| dir_flag | input | 1 | 1 = decrement, 0 = increment |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Code of the segment used |
| cs_o | output | 16 | Current code base |
| ip_o | output | 16 | Current instruction pointer |
| str_next | output | 16 | Stepped string index |

## Verification
Wraparound at the top of memory is exercised from reset, where fetch addresses 0xFFFF0, and by far transfers that place the code base at 0xFFFF with a high pointer. A design that carried into a 21st bit, or clipped instead of wrapping, would produce a wrong low address. Overrides are applied during fetch, and direct writes are aimed at the code segment. A design that let either through would move the fetch address or change `cs_o`. String steps are driven across 0x0000 and 0xFFFF in both directions and with both element sizes, which catches sign and step-size mistakes. Far loads are issued together with near pointer writes, so the wrong priority shows up on `ip_o`.

// File: rtl/seg_pkg.sv
// Shared encodings for the segmented address generator.
// Assumes a 2-bit segment code and a 3-bit base-kind code.
package seg_pkg;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    typedef enum logic [2:0] {
        BASE_IP  = 3'd0,
        BASE_SP  = 3'd1,
        BASE_BP  = 3'd2,
        BASE_BX  = 3'd3,
        BASE_SI  = 3'd4,
        BASE_DI  = 3'd5,
        BASE_DIR = 3'd6,
        BASE_GEN = 3'd7
    } base_e;

    localparam int NUM_SEG = 4;

endpackage

// File: rtl/seg_regfile.sv
// Holds the four segment bases and the instruction pointer.
// Direct writes reach every base except the code base. The code base and
// the pointer load together on a far transfer. Reset is synchronous and
// active low.
module seg_regfile
    import seg_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter logic [SEG_W-1:0] CS_RST = '1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         seg_we,
    input  logic [1:0]                   seg_wsel,
    input  logic [SEG_W-1:0]             seg_wdata,
    input  logic                         far_ld,
    input  logic [SEG_W-1:0]             far_cs,
    input  logic [OFS_W-1:0]             far_ip,
    input  logic                         ip_we,
    input  logic [OFS_W-1:0]             ip_wdata,
    output logic [NUM_SEG-1:0][SEG_W-1:0] seg_q,
    output logic [OFS_W-1:0]             ip_q
);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam logic [1:0] IDX = 2'(g);
        if (IDX == SEG_CS) begin : g_code
            // Code base: changed only by a far transfer.
            always_ff @(posedge clk) begin
                if (!rst_n)      seg_q[g] <= CS_RST;
                else if (far_ld) seg_q[g] <= far_cs;
            end
        end else begin : g_data
            // Other bases: loaded by a matching direct write.
            always_ff @(posedge clk) begin
                if (!rst_n)                         seg_q[g] <= '0;
                else if (seg_we && seg_wsel == IDX) seg_q[g] <= seg_wdata;
            end
        end
    end

    // Instruction pointer: a far load wins over a near load.
    always_ff @(posedge clk) begin
        if (!rst_n)      ip_q <= '0;
        else if (far_ld) ip_q <= far_ip;
        else if (ip_we)  ip_q <= ip_wdata;
    end

endmodule

// File: rtl/seg_select.sv
// Picks the segment code for one access. Fetch always takes the code
// segment. A valid override applies to data accesses only. Otherwise
// stack-relative bases take the stack segment and all others the data
// segment.
module seg_select
    import seg_pkg::*;
(
    input  logic [2:0] acc_base,
    input  logic       ovr_valid,
    input  logic [1:0] ovr_seg,
    output logic [1:0] seg_sel
);

    // Priority: fetch, then override, then default by base kind.
    always_comb begin
        unique case (base_e'(acc_base))
            BASE_IP:          seg_sel = SEG_CS;
            BASE_SP, BASE_BP: seg_sel = ovr_valid ? ovr_seg : SEG_SS;
            default:          seg_sel = ovr_valid ? ovr_seg : SEG_DS;
        endcase
    end

endmodule

// File: rtl/phys_adder.sv
// Forms base * 2^SHIFT + offset and keeps the low ADDR_W bits, so the
// result wraps at the top of the address space.
// Assumes OFS_W <= SEG_W + SHIFT.
module phys_adder #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  base,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr
);

    // Shifted base plus zero-extended offset, modulo 2^ADDR_W.
    always_comb addr = {base, {SHIFT{1'b0}}} + ADDR_W'(ofs);

endmodule

// File: rtl/str_stepper.sv
// Next string index: moves one element up or down according to the
// direction flag. The element is either a byte or a word. The result
// wraps in OFS_W bits.
module str_stepper #(
    parameter int OFS_W = 16
) (
    input  logic [OFS_W-1:0] idx,
    input  logic             word,
    input  logic             dir,
    output logic [OFS_W-1:0] nxt
);

    logic [OFS_W-1:0] step;

    // Element size in bytes.
    always_comb step = word ? OFS_W'(2) : OFS_W'(1);

    // Decrement when the direction flag is set, increment otherwise.
    always_comb nxt = dir ? (idx - step) : (idx + step);

endmodule

// File: rtl/seg_addr_gen.sv
// Top level of the segmented physical address generator.
// Holds the bases and the instruction pointer, picks a segment per
// access, forms the wrapped physical address and steps string indexes.
// Address and step outputs are combinational. Register updates land at
// the next clock edge.
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_we,
    input  logic [1:0]        seg_wsel,
    input  logic [SEG_W-1:0]  seg_wdata,
    input  logic              far_ld,
    input  logic [SEG_W-1:0]  far_cs,
    input  logic [OFS_W-1:0]  far_ip,
    input  logic              ip_we,
    input  logic [OFS_W-1:0]  ip_wdata,
    input  logic [2:0]        acc_base,
    input  logic [OFS_W-1:0]  offset,
    input  logic              ovr_valid,
    input  logic [1:0]        ovr_seg,
    input  logic [OFS_W-1:0]  str_idx,
    input  logic              str_word,
    input  logic              dir_flag,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [1:0]        seg_used,
    output logic [SEG_W-1:0]  cs_o,
    output logic [OFS_W-1:0]  ip_o,
    output logic [OFS_W-1:0]  str_next
);

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
    logic [OFS_W-1:0]              ip_q;
    logic [1:0]                    sel;
    logic [OFS_W-1:0]              eff_ofs;

    seg_regfile #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_we    (seg_we),
        .seg_wsel  (seg_wsel),
        .seg_wdata (seg_wdata),
        .far_ld    (far_ld),
        .far_cs    (far_cs),
        .far_ip    (far_ip),
        .ip_we     (ip_we),
        .ip_wdata  (ip_wdata),
        .seg_q     (seg_q),
        .ip_q      (ip_q)
    );

    seg_select u_sel (
        .acc_base  (acc_base),
        .ovr_valid (ovr_valid),
        .ovr_seg   (ovr_seg),
        .seg_sel   (sel)
    );

    // Fetch takes its offset from the instruction pointer.
    always_comb eff_ofs = (base_e'(acc_base) == BASE_IP) ? ip_q : offset;

    phys_adder #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W),
        .SHIFT (SHIFT)
    ) u_add (
        .base (seg_q[sel]),
        .ofs  (eff_ofs),
        .addr (phys_addr)
    );

    str_stepper #(
        .OFS_W (OFS_W)
    ) u_step (
        .idx  (str_idx),
        .word (str_word),
        .dir  (dir_flag),
        .nxt  (str_next)
    );

    // Expose the chosen segment and the code-side state.
    always_comb begin
        seg_used = sel;
        cs_o     = seg_q[SEG_CS];
        ip_o     = ip_q;
    end

endmodule

// File: rtl/seg_addr_gen_chk.sv
// Properties for seg_addr_gen, attached through bind. Observes only the
// top-level ports.
module seg_addr_gen_chk #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             far_ld,
    input logic [SEG_W-1:0] far_cs,
    input logic [OFS_W-1:0] far_ip,
    input logic             ip_we,
    input logic [2:0]       acc_base,
    input logic             ovr_valid,
    input logic [1:0]       ovr_seg,
    input logic [1:0]       seg_used,
    input logic [SEG_W-1:0] cs_o,
    input logic [OFS_W-1:0] ip_o,
    input logic [OFS_W-1:0] str_idx,
    input logic [OFS_W-1:0] str_next
);

    // R7
    cs_write_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !far_ld |=> $stable(cs_o));

    // R8
    far_pair_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        far_ld |=> (cs_o == $past(far_cs) && ip_o == $past(far_ip)));

    // R8
    ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!far_ld && !ip_we) |=> $stable(ip_o));

    // R3
    fetch_code_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_base == 3'd0) |-> (seg_used == 2'd1));

    // R6
    override_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_base != 3'd0 && ovr_valid) |-> (seg_used == ovr_seg));

    // R9
    str_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        str_next != str_idx);

endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_seg_addr_gen.sv
`timescale 1ns/1ps
module tb_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seg_we, far_ld, ip_we, ovr_valid, str_word, dir_flag;
    logic [1:0]  seg_wsel, ovr_seg;
    logic [15:0] seg_wdata, far_cs, far_ip, ip_wdata, offset, str_idx;
    logic [2:0]  acc_base;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;
    logic [15:0] cs_o, ip_o, str_next;

    int nvec = 0;
    int nfail = 0;
    logic [15:0] sh_seg [4];
    logic [15:0] sh_ip;

    always #2 clk = ~clk;

    seg_addr_gen dut (.*);

    function automatic logic [1:0] exp_sel(logic [2:0] b, logic ov, logic [1:0] os);
        if (b == 3'd0) return 2'd1;
        if (ov) return os;
        return (b == 3'd1 || b == 3'd2) ? 2'd2 : 2'd3;
    endfunction

    function automatic logic [19:0] exp_addr(logic [15:0] s, logic [15:0] o);
        logic [20:0] full;
        full = {1'b0, s, 4'h0} + {5'h0, o};
        return full[19:0];
    endfunction

    function automatic logic [15:0] exp_step(logic [15:0] i, logic w, logic d);
        int unsigned st;
        st = w ? 2 : 1;
        return d ? 16'(i - st) : 16'(i + st);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        nvec++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic idle();
        seg_we = 0; far_ld = 0; ip_we = 0; ovr_valid = 0;
        seg_wsel = 0; ovr_seg = 0; seg_wdata = 0; far_cs = 0; far_ip = 0;
        ip_wdata = 0; acc_base = 3'd3; offset = 0; str_idx = 0;
        str_word = 0; dir_flag = 0;
    endtask

    // Check combinational outputs for the present inputs and shadow state.
    task automatic check_comb(string tag);
        logic [1:0] s;
        logic [15:0] o;
        s = exp_sel(acc_base, ovr_valid, ovr_seg);
        o = (acc_base == 3'd0) ? sh_ip : offset;
        chk({tag, " R10"}, 32'(seg_used), 32'(s));
        chk({tag, " R2"}, 32'(phys_addr), 32'(exp_addr(sh_seg[s], o)));
        chk("R9", 32'(str_next), 32'(exp_step(str_idx, str_word, dir_flag)));
    endtask

    // Shadow the state update implied by the strobes now applied.
    task automatic commit();
        if (far_ld) begin
            sh_seg[1] = far_cs;
            sh_ip = far_ip;
        end else if (ip_we) begin
            sh_ip = ip_wdata;
        end
        if (seg_we && seg_wsel != 2'd1) sh_seg[seg_wsel] = seg_wdata;
    endtask

    task automatic step_cycle();
        #1 check_comb("cyc");
        commit();
        @(negedge clk);
        chk("R7/R8 cs", 32'(cs_o), 32'(sh_seg[1]));
        chk("R8 ip", 32'(ip_o), 32'(sh_ip));
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_abcd));
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        sh_seg[0] = 0; sh_seg[1] = 16'hFFFF; sh_seg[2] = 0; sh_seg[3] = 0; sh_ip = 0;

        // R1 reset state, fetch lands at FFFF0
        chk("R1 cs", 32'(cs_o), 32'hFFFF);
        chk("R1 ip", 32'(ip_o), 32'h0);
        acc_base = 3'd0;
        #1 chk("R1 fetch addr", 32'(phys_addr), 32'hFFFF0);
        acc_base = 3'd1; offset = 16'h1234;
        #1 chk("R1 ss zero R4", 32'(phys_addr), 32'h01234);
        acc_base = 3'd3; ovr_valid = 1; ovr_seg = 2'd0;
        #1 chk("R1 es zero R6", 32'(phys_addr), 32'h01234);
        idle();
        @(negedge clk);

        // R7 direct write naming the code segment is ignored
        seg_we = 1; seg_wsel = 2'd1; seg_wdata = 16'h0042;
        step_cycle();
        chk("R7 cs write blocked", 32'(cs_o), 32'hFFFF);
        idle();

        // R3 fetch ignores override and offset; R2 wrap at top of memory
        far_ld = 1; far_cs = 16'hFFFF; far_ip = 16'h0010;
        ip_we = 1; ip_wdata = 16'h5555;
        step_cycle();
        chk("R8 far over near", 32'(ip_o), 32'h0010);
        idle();
        acc_base = 3'd0; ovr_valid = 1; ovr_seg = 2'd3; offset = 16'hAAAA;
        #1 chk("R3 R2 wrap", 32'(phys_addr), 32'h00000);
        chk("R3 seg", 32'(seg_used), 32'd1);
        @(negedge clk);

        // R6 override to code segment for a data access, R2 wrap
        acc_base = 3'd4; ovr_valid = 1; ovr_seg = 2'd1; offset = 16'hFFFF;
        #1 chk("R6 R2 code ovr wrap", 32'(phys_addr), 32'h0FFEF);
        idle();
        @(negedge clk);

        // R9 directed index wrap cases
        str_idx = 16'h0000; dir_flag = 1; str_word = 0;
        #1 chk("R9 dec wrap", 32'(str_next), 32'hFFFF);
        str_idx = 16'hFFFF; dir_flag = 0; str_word = 1;
        #1 chk("R9 inc word wrap", 32'(str_next), 32'h0001);
        str_idx = 16'h0001; dir_flag = 1; str_word = 1;
        #1 chk("R9 dec word wrap", 32'(str_next), 32'hFFFF);
        idle();
        @(negedge clk);

        // R4 R5 R6 R7 R8: constrained random mix
        for (int i = 0; i < 3000; i++) begin
            seg_we    = ($urandom % 3) == 0;
            seg_wsel  = 2'($urandom);
            seg_wdata = 16'($urandom);
            far_ld    = ($urandom % 8) == 0;
            far_cs    = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom);
            far_ip    = 16'($urandom);
            ip_we     = ($urandom % 4) == 0;
            ip_wdata  = 16'($urandom);
            acc_base  = 3'($urandom);
            offset    = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom);
            ovr_valid = ($urandom % 3) == 0;
            ovr_seg   = 2'($urandom);
            str_idx   = 16'($urandom);
            str_word  = 1'($urandom);
            dir_flag  = 1'($urandom);
            step_cycle();
        end
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule